// File: doc/BRIEF.md
# Pending-Interrupt Register with Channel Loop Encoding

This block holds the interrupt status and interrupt enable words of a multi-channel audio engine. A set of event sources (buffer half-full and full, timer terminal count, MIDI transmit and receive, bus error, front-panel buttons and similar) each deliver a one-cycle pulse. A pulse latches a pending bit that stays set until software clears it by writing a 1 to that bit position. The engine also raises per-channel loop pulses that carry a channel number. These set one of up to 64 loop flags. A single summary bit represents all of those flags, and the status word carries the index of the highest-numbered pending channel beside it.

Software clears one loop flag at a time. It writes the status word with the summary bit set and the channel number in the low six bits. A separate enable word gates each source onto a single registered level interrupt output. One enable bit forces that output high whatever is pending. The host reaches both words through a one-bit address, a write strobe and a read data bus that is valid in the same cycle as the address.

Top module: `intr_pending_reg`

## Requirements
- R1: After reset, every pending bit, every loop flag and every enable bit is 0, and `irqOut` is 0.
- R2: A pulse on `evtPulse[i]` sets pending bit i. The host reads that bit at status position 7+i. It stays set until it is cleared. Status bits above position 6+NUM_EVT read 0.
- R3: A host write to address 0 clears each event pending bit whose position is written as 1. Positions written as 0 keep their value.
- R4: If an event pulse and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R5: A pulse on `loopPulse` sets the loop flag numbered by `loopChan`. Status bit 6 reads 1 whenever any loop flag is set, and 0 when none is.
- R6: Status bits 5:0 read the largest channel number whose loop flag is set. They read 0 when no flag is set.
- R7: A status write with bit 6 set clears only the loop flag numbered by bits 5:0 of the written value. A status write with bit 6 clear leaves every loop flag unchanged.
- R8: A write to address 1 loads the enable word, and a read of address 1 returns it. Bits NUM_EVT-1:0 enable the event sources, bit NUM_EVT enables the loop summary and bit FORCE_POS is the force bit. All other enable bits read 0.
- R9: `irqOut` is a register output. It is 1 exactly when some pending event bit has its enable set, or a loop flag is pending with the loop enable set, or the force bit is set. It reflects the status and enable state present in the same cycle.
- R10: While the force bit is set, `irqOut` is 1 even with nothing pending.
- R11: If a loop pulse and a clear of the same channel fall in the same cycle, that channel's flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostAddr | input | 1 | 0 selects the status word, 1 selects the enable word |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Word selected by hostAddr |
| evtPulse | input | NUM_EVT | One-cycle event pulses, one per source |
| loopPulse | input | 1 | One-cycle channel loop pulse |
| loopChan | input | clog2(NUM_CHAN) | Channel number carried by loopPulse |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: twelve event sources, 64 loop channels and the force bit at position 20. With these values the top event bit lands at status position 18, channel 63 fills all six index bits, and the force bit sits well clear of the event enables. The bench can therefore reach the extreme channel indices, a clear of channel 0 through an all-zero index field, and a force bit that no event enable overlaps. Directed cycles exercise the same-cycle set-versus-clear races for both events and loop flags. Long random stretches then mix enable rewrites, partial clears and bursts of loop pulses.

// File: rtl/intr_pend_pkg.sv
package intr_pend_pkg;
  localparam int REG_W        = 32;
  localparam int IDX_W        = 6;
  localparam int LOOP_SUM_POS = 6;
  localparam int EVT_BASE     = 7;

  typedef struct packed {
    logic             enLoad;
    logic             loopClr;
    logic [IDX_W-1:0] loopIdx;
  } pendStrobe_t;
endpackage

// File: rtl/intr_pend_ctrl.sv
module intr_pend_ctrl
  import intr_pend_pkg::*;
#(
  parameter int NUM_EVT = 12
) (
  input  logic               hostAddr,
  input  logic               hostWrEn,
  input  logic [REG_W-1:0]   hostWrData,
  input  logic [REG_W-1:0]   statusWord,
  input  logic [REG_W-1:0]   enableWord,
  output pendStrobe_t        strb,
  output logic [NUM_EVT-1:0] evtClr,
  output logic [REG_W-1:0]   enData,
  output logic [REG_W-1:0]   hostRdData
);
  logic statWrite;

  always_comb begin
    statWrite    = hostWrEn && !hostAddr;
    strb.enLoad  = hostWrEn && hostAddr;
    strb.loopClr = statWrite && hostWrData[LOOP_SUM_POS];
    strb.loopIdx = hostWrData[IDX_W-1:0];
    evtClr       = statWrite ? hostWrData[EVT_BASE +: NUM_EVT] : '0;
    enData       = hostWrData;
    hostRdData   = hostAddr ? enableWord : statusWord;
  end
endmodule

// File: rtl/intr_pend_datapath.sv
module intr_pend_datapath
  import intr_pend_pkg::*;
#(
  parameter int NUM_EVT   = 12,
  parameter int NUM_CHAN  = 64,
  parameter int FORCE_POS = 20,
  localparam int CH_W     = $clog2(NUM_CHAN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  pendStrobe_t        strb,
  input  logic [NUM_EVT-1:0] evtClr,
  input  logic [REG_W-1:0]   enData,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               loopPulse,
  input  logic [CH_W-1:0]    loopChan,
  output logic [REG_W-1:0]   statusWord,
  output logic [REG_W-1:0]   enableWord,
  output logic               irqOut
);
  localparam logic [REG_W-1:0] EN_MASK =
    ((REG_W'(1) << (NUM_EVT + 1)) - REG_W'(1)) | (REG_W'(1) << FORCE_POS);

  logic [NUM_EVT-1:0]  evtPend, evtNxt;
  logic [NUM_CHAN-1:0] loopFlag, loopNxt;
  logic [REG_W-1:0]    enReg, enNxt;
  logic                irqNxt;
  logic [IDX_W-1:0]    topIdx;
  logic                loopAny;

  assign evtNxt = (evtPend & ~evtClr) | evtPulse;
  assign enNxt  = strb.enLoad ? (enData & EN_MASK) : enReg;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_loop
    logic setHit, clrHit;
    assign setHit     = loopPulse && (loopChan == CH_W'(c));
    assign clrHit     = strb.loopClr && (strb.loopIdx == IDX_W'(c));
    assign loopNxt[c] = (loopFlag[c] && !clrHit) || setHit;
  end

  assign irqNxt = (|(evtNxt & enNxt[NUM_EVT-1:0]))
               || ((|loopNxt) && enNxt[NUM_EVT])
               || enNxt[FORCE_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPend  <= '0;
      loopFlag <= '0;
      enReg    <= '0;
      irqOut   <= 1'b0;
    end else begin
      evtPend  <= evtNxt;
      loopFlag <= loopNxt;
      enReg    <= enNxt;
      irqOut   <= irqNxt;
    end
  end

  // highest pending channel: later (larger) hits overwrite earlier ones
  always_comb begin
    topIdx = '0;
    for (int c = 0; c < NUM_CHAN; c++)
      if (loopFlag[c]) topIdx = IDX_W'(c);
  end

  assign loopAny = |loopFlag;

  always_comb begin
    statusWord = '0;
    statusWord[EVT_BASE +: NUM_EVT] = evtPend;
    statusWord[LOOP_SUM_POS]        = loopAny;
    statusWord[IDX_W-1:0]           = topIdx;
  end

  assign enableWord = enReg;

  // R2
  evt_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((evtPend & $past(evtPulse)) == $past(evtPulse)));

  // R3
  evt_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(evtClr & ~evtPulse)) |=> ((evtPend & $past(evtClr & ~evtPulse)) == '0));

  // R5
  loop_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopPulse |=> loopFlag[$past(loopChan)]);

  // R7
  loop_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loopClr && (int'(strb.loopIdx) < NUM_CHAN)
      && !(loopPulse && (IDX_W'(loopChan) == strb.loopIdx)))
    |=> !loopFlag[CH_W'($past(strb.loopIdx))]);

  // R10
  force_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    enReg[FORCE_POS] |-> irqOut);

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg[FORCE_POS] && ((evtPend & enReg[NUM_EVT-1:0]) == '0)
      && !(loopAny && enReg[NUM_EVT])) |-> !irqOut);
endmodule

// File: rtl/intr_pending_reg.sv
module intr_pending_reg
  import intr_pend_pkg::*;
#(
  parameter int NUM_EVT   = 12,
  parameter int NUM_CHAN  = 64,
  parameter int FORCE_POS = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostAddr,
  input  logic                        hostWrEn,
  input  logic [31:0]                 hostWrData,
  output logic [31:0]                 hostRdData,
  input  logic [NUM_EVT-1:0]          evtPulse,
  input  logic                        loopPulse,
  input  logic [$clog2(NUM_CHAN)-1:0] loopChan,
  output logic                        irqOut
);
  pendStrobe_t        strb;
  logic [NUM_EVT-1:0] evtClr;
  logic [REG_W-1:0]   enData, statusWord, enableWord;

  intr_pend_ctrl #(.NUM_EVT(NUM_EVT)) ctrl_i (
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .statusWord (statusWord),
    .enableWord (enableWord),
    .strb       (strb),
    .evtClr     (evtClr),
    .enData     (enData),
    .hostRdData (hostRdData)
  );

  intr_pend_datapath #(
    .NUM_EVT   (NUM_EVT),
    .NUM_CHAN  (NUM_CHAN),
    .FORCE_POS (FORCE_POS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .evtClr     (evtClr),
    .enData     (enData),
    .evtPulse   (evtPulse),
    .loopPulse  (loopPulse),
    .loopChan   (loopChan),
    .statusWord (statusWord),
    .enableWord (enableWord),
    .irqOut     (irqOut)
  );
endmodule

// File: tb/intr_pending_reg_tb_top.sv
module intr_pending_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EVT    = 12;
  localparam int NUM_CHAN   = 64;
  localparam int FORCE_POS  = 20;
  localparam int CH_W       = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostAddr = 1'b0;
  logic hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic loopPulse = 1'b0;
  logic [CH_W-1:0] loopChan = '0;
  logic irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_pending_reg #(.NUM_EVT(NUM_EVT), .NUM_CHAN(NUM_CHAN), .FORCE_POS(FORCE_POS)) dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .evtPulse(evtPulse),
    .loopPulse(loopPulse), .loopChan(loopChan), .irqOut(irqOut)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  bit [NUM_EVT-1:0]  mEvt = '0;
  bit [NUM_CHAN-1:0] mLoop = '0;
  bit [31:0]         mEn = '0;

  function automatic int highestChan();
    int r = 0;
    for (int c = 0; c < NUM_CHAN; c++) if (mLoop[c]) r = c;
    return r;
  endfunction

  function automatic bit expIrq();
    bit r = mEn[FORCE_POS];
    for (int i = 0; i < NUM_EVT; i++) if (mEvt[i] && mEn[i]) r = 1;
    if ((mLoop != 0) && mEn[NUM_EVT]) r = 1;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    logic [31:0] st, en;
    hostAddr = 1'b0; #1 st = hostRdData;
    hostAddr = 1'b1; #1 en = hostRdData;
    check("R2 R3 R4 event bits", 32'(st[7 +: NUM_EVT]), 32'(mEvt));
    check("R2 unused status bits", 32'(st[31:7+NUM_EVT]), 32'd0);
    check("R5 loop summary", 32'(st[6]), 32'(mLoop != 0));
    check("R6 R7 R11 channel index", 32'(st[5:0]), 32'(highestChan()));
    check("R8 enable readback", en, mEn);
    check("R9 R10 irq level", 32'(irqOut), 32'(expIrq()));
  endtask

  task automatic step(input bit wr, input bit addr, input logic [31:0] data,
                      input logic [NUM_EVT-1:0] evt, input bit lp, input int lch);
    @(negedge clk);
    compareAll();
    hostWrEn = wr; hostAddr = addr; hostWrData = data;
    evtPulse = evt; loopPulse = lp; loopChan = CH_W'(lch);
    // reference update for the coming edge
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt[i]) mEvt[i] = 1;
      else if (wr && !addr && data[7+i]) mEvt[i] = 0;
    end
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (lp && lch == c) mLoop[c] = 1;
      else if (wr && !addr && data[6] && int'(data[5:0]) == c) mLoop[c] = 0;
    end
    if (wr && addr) begin
      mEn = '0;
      for (int b = 0; b <= NUM_EVT; b++) mEn[b] = data[b];
      mEn[FORCE_POS] = data[FORCE_POS];
    end
  endtask

  task automatic idle();
    step(0, 0, 32'd0, '0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    hostAddr = 0; #1 rv = hostRdData; check("R1 status after reset", rv, 32'd0);
    hostAddr = 1; #1 rv = hostRdData; check("R1 enable after reset", rv, 32'd0);
    check("R1 irq after reset", 32'(irqOut), 32'd0);
    rstN = 1'b1;
    idle();
    // enable every event and the loop summary
    step(1, 1, 32'hFFFF_FFFF, '0, 0, 0);          // R8 masking of unused bits
    step(1, 1, 32'h0000_1FFF, '0, 0, 0);
    step(0, 0, 0, 12'h008, 0, 0);                 // R2 set event 3
    idle();
    step(1, 0, 32'h1 << 10, '0, 0, 0);            // R3 clear event 3
    step(0, 0, 0, 12'h028, 0, 0);                 // events 3 and 5
    step(1, 0, 32'h1 << 10, '0, 0, 0);            // R3 only event 3 cleared
    idle();
    step(0, 0, 0, 12'h004, 0, 0);
    step(1, 0, 32'h1 << 9, 12'h004, 0, 0);        // R4 clear and pulse race
    idle();
    step(1, 0, 32'hFFFF_FF80, '0, 0, 0);          // clear all events
    // loop flags
    step(0, 0, 0, '0, 1, 10);                     // R5
    step(0, 0, 0, '0, 1, 63);                     // R6 top index
    step(0, 0, 0, '0, 1, 0);
    idle();
    step(1, 0, 32'h40 | 32'd63, '0, 0, 0);        // R7 clear 63
    idle();
    step(1, 0, 32'd10, '0, 0, 0);                 // R7 bit 6 clear: no effect
    step(1, 0, 32'h40 | 32'd20, '0, 0, 0);        // R7 clearing idle channel
    step(1, 0, 32'h40 | 32'd10, '0, 1, 10);       // R11 race on channel 10
    idle();
    step(1, 0, 32'h40 | 32'd10, '0, 0, 0);
    step(1, 0, 32'h40, '0, 0, 0);                 // R7 clear channel 0
    idle();
    // force and enable gating
    step(1, 1, 32'h1 << FORCE_POS, '0, 0, 0);     // R10
    idle();
    step(0, 0, 0, 12'h002, 0, 0);                 // R9 masked event
    step(1, 1, 32'd0, '0, 0, 0);
    idle();
    step(1, 1, 32'h2, '0, 0, 0);                  // R9 enable unmasks it
    idle();
    step(0, 0, 0, '0, 1, 33);
    step(1, 1, 32'h1 << NUM_EVT, '0, 0, 0);       // R9 loop enable only
    idle();
    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      bit wr = ($urandom % 3) == 0;
      bit ad = ($urandom % 4) == 0;
      logic [31:0] d = $urandom;
      logic [NUM_EVT-1:0] e = NUM_EVT'($urandom & $urandom & $urandom);
      bit lp = ($urandom % 3) == 0;
      int ch = ($urandom % 2) ? int'($urandom % 64) : 56 + int'($urandom % 8);
      if (ad && ($urandom % 4 != 0)) d[FORCE_POS] = 1'b0;
      step(wr, ad, d, e, lp, ch);
    end
    idle();
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule